// File: doc/BRIEF.md
# Serial Byte Transmitter with Memory-Transfer Request

This block sends 8-bit bytes on a single serial line. Software, or a memory-transfer engine, writes a byte into one holding register over a small write port. Once the transmitter is switched on and the baud timing is valid, that byte moves into a shift register. It then leaves as a frame: a low start bit, the data bits least significant first, and a high stop bit. While nothing is being sent, the line rests high.

The bit time is the product of two programmable values. A prescale divisor sets the length of one sample period. An oversampling count, stored as the ratio minus one, sets how many sample periods make one bit. A divisor of zero stops the generator, and no frame is sent.

The empty state of the holding register can be routed out as a level request to a memory-transfer engine. The engine answers each request by writing the next byte. An acknowledge pulse hides the request from the moment the engine accepts it until that write arrives, so that one empty slot does not draw two transfers.

Top module: `uart_tx_dma`

## Requirements
- R1: After synchronous reset `tx` is 1 and `dma_req` is 0. Reset also leaves the divisor at 0, the oversampling field at 15, both control bits at 0 and the holding register empty.
- R2: A frame is one 0 start bit, then data bits 0 to 7 in that order, then one 1 stop bit. Between frames `tx` is 1.
- R3: Register address 0 holds the divisor in bits [12:0] and the oversampling field in bits [20:16]. Every frame bit lasts exactly (field + 1) × divisor clock cycles, so a field of 15 gives 16 sample periods per bit.
- R4: Bit 0 of register address 1 enables transmission. While it is 0 no frame starts, a frame in flight is abandoned, `tx` is 1, and a written byte waits in the holding register. Once the bit is set, the start bit begins on the second clock edge after the write that set it.
- R5: A write to register address 2 puts bits [7:0] into the holding register and clears the empty state, starting in the next cycle. The empty state returns on the clock edge at which the byte moves into the shift register, one edge after the write when the line is idle. The start bit begins on that same edge.
- R6: Bit 1 of register address 1 routes the empty state to `dma_req`. When this bit is 0, `dma_req` is 0 starting in the cycle after the write, even if the holding register is empty.
- R7: While the divisor is 0 no frame starts and `tx` stays 1. A waiting byte is sent once a nonzero divisor is written, with the same timing as in R4.
- R8: A cycle with `dma_ack` at 1 forces `dma_req` to 0 from the next cycle until a write to register address 2 arrives.
- R9: A byte that is waiting when a stop bit ends starts its own start bit in the very next cycle, with no idle cycle between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 rate, 1 control, 2 data |
| wr_data | input | 32 | Register write value |
| dma_ack | input | 1 | Transfer engine has accepted the current request |
| tx | output | 1 | Serial output, idles high |
| dma_req | output | 1 | Level request for a new byte |

## Verification
The bench keeps the default widths (5-bit oversampling field, 13-bit divisor) and programs small values only: a ratio of 1 to 8 with a divisor of 1 to 3 in random frames, plus directed frames at 16 × 1 and 4 × 2. These values make a single-cycle bit time and short frames possible. Every cycle of every frame can then be compared against the expected line level, so bit boundaries are checked to the exact cycle. Directed cases cover the zero divisor, a disabled transmitter holding a byte, back-to-back frames and the acknowledge mask.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int DATA_BITS = 8;
    localparam int FRAME_LEN = DATA_BITS + 2;
    localparam int OVS_LSB   = 16;

    typedef enum logic [1:0] {
        REG_RATE = 2'd0,
        REG_CTRL = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic dma_en;
        logic tx_en;
    } ctrl_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(input logic [DATA_BITS-1:0] d);
        return {1'b1, d, 1'b0};
    endfunction

endpackage

// File: rtl/utx_regs.sv
module utx_regs
    import utx_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int ADDR_W  = 2,
    parameter int OVS_W   = 5,
    parameter int DIV_W   = 13,
    parameter int OVS_RST = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 dma_ack,
    input  logic                 load,
    output logic [OVS_W-1:0]     ovs,
    output logic [DIV_W-1:0]     div,
    output ctrl_t                ctrl,
    output logic [DATA_BITS-1:0] hold,
    output logic                 full,
    output logic                 dma_req
);
    logic empty;
    logic ack_pend;
    logic unused_ok;

    assign unused_ok = &{1'b0, wr_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            ovs      <= OVS_W'(OVS_RST);
            div      <= '0;
            ctrl     <= '0;
            hold     <= '0;
            empty    <= 1'b1;
            ack_pend <= 1'b0;
        end else begin
            if (load)    empty    <= 1'b1;
            if (dma_ack) ack_pend <= 1'b1;
            if (wr_en) begin
                case (reg_sel_e'(wr_addr[1:0]))
                    REG_RATE: begin
                        div <= wr_data[DIV_W-1:0];
                        ovs <= wr_data[OVS_LSB +: OVS_W];
                    end
                    REG_CTRL: ctrl <= ctrl_t'(wr_data[1:0]);
                    REG_DATA: begin
                        hold     <= wr_data[DATA_BITS-1:0];
                        empty    <= 1'b0;
                        ack_pend <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign full    = ~empty;
    assign dma_req = ctrl.dma_en & empty & ~ack_pend;

endmodule

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int OVS_W = 5,
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [OVS_W-1:0] ovs,
    input  logic [DIV_W-1:0] div,
    output logic             bit_tick
);
    logic [DIV_W-1:0] pre_cnt;
    logic [OVS_W-1:0] smp_cnt;
    logic             pre_wrap;
    logic             smp_wrap;

    assign pre_wrap = (pre_cnt == div - DIV_W'(1));
    assign smp_wrap = (smp_cnt == ovs);
    assign bit_tick = pre_wrap & smp_wrap;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_cnt <= '0;
            smp_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            smp_cnt <= smp_wrap ? '0 : smp_cnt + OVS_W'(1);
        end else begin
            pre_cnt <= pre_cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/utx_shift.sv
module utx_shift
    import utx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 bit_tick,
    input  logic                 full,
    input  logic [DATA_BITS-1:0] hold,
    output logic                 load,
    output logic                 busy,
    output logic                 tx
);
    localparam int IDX_W = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] sh;
    logic [IDX_W-1:0]     idx;
    logic                 last;

    assign last = (idx == IDX_W'(FRAME_LEN - 1));
    assign load = run & full & (~busy | (bit_tick & last));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            idx  <= '0;
        end else if (!run) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sh   <= build_frame(hold);
            idx  <= '0;
        end else if (busy && bit_tick) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                sh  <= {1'b1, sh[FRAME_LEN-1:1]};
                idx <= idx + IDX_W'(1);
            end
        end
    end

    assign tx = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/uart_tx_dma.sv
module uart_tx_dma
    import utx_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 2,
    parameter int OVS_W  = 5,
    parameter int DIV_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              dma_ack,
    output logic              tx,
    output logic              dma_req
);
    logic [OVS_W-1:0]     ovs;
    logic [DIV_W-1:0]     div;
    ctrl_t                ctrl;
    logic [DATA_BITS-1:0] hold;
    logic                 full;
    logic                 load;
    logic                 busy;
    logic                 bit_tick;
    logic                 div_zero;
    logic                 tx_en;
    logic                 run;
    logic                 baud_clear;

    assign div_zero   = (div == '0);
    assign tx_en      = ctrl.tx_en;
    assign run        = tx_en & ~div_zero;
    assign baud_clear = ~busy | load | ~run;

    utx_regs #(
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W),
        .OVS_W  (OVS_W),
        .DIV_W  (DIV_W),
        .OVS_RST(15)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dma_ack (dma_ack),
        .load    (load),
        .ovs     (ovs),
        .div     (div),
        .ctrl    (ctrl),
        .hold    (hold),
        .full    (full),
        .dma_req (dma_req)
    );

    utx_baud #(
        .OVS_W(OVS_W),
        .DIV_W(DIV_W)
    ) u_baud (
        .clk     (clk),
        .rst     (rst),
        .clear   (baud_clear),
        .ovs     (ovs),
        .div     (div),
        .bit_tick(bit_tick)
    );

    utx_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .bit_tick(bit_tick),
        .full    (full),
        .hold    (hold),
        .load    (load),
        .busy    (busy),
        .tx      (tx)
    );

endmodule

// File: rtl/utx_chk.sv
module utx_chk
    import utx_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              dma_ack,
    input logic              tx,
    input logic              dma_req,
    input logic              busy,
    input logic              div_zero,
    input logic              tx_en
);
    logic data_wr;
    logic ctrl_wr;

    assign data_wr = wr_en && (wr_addr[1:0] == REG_DATA);
    assign ctrl_wr = wr_en && (wr_addr[1:0] == REG_CTRL);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tx && !dma_req));

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);

    // R4
    halt_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !busy);

    // R5
    dreq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> !dma_req);

    // R6
    dma_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wr_data[1]) |=> !dma_req);

    // R7
    div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (div_zero && !busy) |=> !busy);

    // R8
    ack_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_ack && !data_wr) |=> !dma_req);

endmodule

bind uart_tx_dma utx_chk #(
    .REG_W (REG_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .dma_ack (dma_ack),
    .tx      (tx),
    .dma_req (dma_req),
    .busy    (busy),
    .div_zero(div_zero),
    .tx_en   (tx_en)
);

// File: tb/sim_uart_tx_dma.sv
module sim_uart_tx_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        dma_ack = 1'b0;
    logic        tx;
    logic        dma_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    uart_tx_dma u0 (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .dma_ack(dma_ack),
        .tx     (tx),
        .dma_req(dma_req)
    );

    function automatic logic exp_bit(input logic [7:0] b, input int k);
        if (k == 0) return 1'b0;
        if (k == 9) return 1'b1;
        return b[k-1];
    endfunction

    function automatic logic [31:0] rate_word(input int ovs, input int dv);
        return (32'(ovs) << 16) | 32'(dv);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // called at the negedge of frame cycle 0; returns at the cycle after the stop bit
    task automatic check_frame(input logic [7:0] b, input int t, input string req);
        for (int i = 0; i < 10 * t; i++) begin
            chk(req, 32'(tx), 32'(exp_bit(b, i / t)));
            @(negedge clk);
        end
    endtask

    task automatic hold_idle(input int n, input string req);
        logic seen_low = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (tx !== 1'b1) seen_low = 1'b1;
            @(negedge clk);
        end
        chk(req, 32'(seen_low), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int ovs;
        int dv;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", 32'(tx), 32'd1);
        chk("R1", 32'(dma_req), 32'd0);

        // R6 route empty to request; R3 ratio field 15 -> 16 samples of 1 clock
        wr(2'd0, rate_word(15, 1));
        wr(2'd1, 32'h3);
        chk("R6", 32'(dma_req), 32'd1);

        // R5 write clears empty, load refills it one edge later
        wr(2'd2, 32'hA5);
        chk("R5", 32'(dma_req), 32'd0);
        chk("R5", 32'(tx), 32'd1);
        @(negedge clk);
        chk("R5", 32'(dma_req), 32'd1);
        check_frame(8'hA5, 16, "R3");
        chk("R2", 32'(tx), 32'd1);

        // R9 back-to-back frames, ratio 4 x divisor 2
        wr(2'd0, rate_word(3, 2));
        wr(2'd2, 32'h3C);
        wr(2'd2, 32'hC3);
        check_frame(8'h3C, 8, "R9");
        check_frame(8'hC3, 8, "R9");
        chk("R2", 32'(tx), 32'd1);

        // R6 clearing the route drops the request
        chk("R6", 32'(dma_req), 32'd1);
        wr(2'd1, 32'h1);
        chk("R6", 32'(dma_req), 32'd0);
        wr(2'd1, 32'h3);
        chk("R6", 32'(dma_req), 32'd1);

        // R8 acknowledge hides request until the data write
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        chk("R8", 32'(dma_req), 32'd0);
        repeat (5) @(negedge clk);
        chk("R8", 32'(dma_req), 32'd0);
        wr(2'd2, 32'h5A);
        chk("R8", 32'(dma_req), 32'd0);
        @(negedge clk);
        chk("R8", 32'(dma_req), 32'd1);
        check_frame(8'h5A, 8, "R8");

        // R4 transmitter off: byte waits, line idle
        wr(2'd1, 32'h2);
        wr(2'd2, 32'h81);
        hold_idle(40, "R4");
        chk("R4", 32'(dma_req), 32'd0);
        wr(2'd1, 32'h3);
        chk("R4", 32'(tx), 32'd1);
        @(negedge clk);
        check_frame(8'h81, 8, "R4");

        // R7 zero divisor stops generator
        wr(2'd0, rate_word(3, 0));
        wr(2'd2, 32'h7E);
        hold_idle(40, "R7");
        chk("R7", 32'(dma_req), 32'd0);
        wr(2'd0, rate_word(0, 2));
        chk("R7", 32'(tx), 32'd1);
        @(negedge clk);
        check_frame(8'h7E, 2, "R7");

        // R2 R3 random frames
        for (int n = 0; n < 24; n++) begin
            ovs = int'($urandom_range(0, 7));
            dv  = int'($urandom_range(1, 3));
            b   = 8'($urandom);
            wr(2'd0, rate_word(ovs, dv));
            wr(2'd2, 32'(b));
            chk("R5", 32'(dma_req), 32'd0);
            @(negedge clk);
            check_frame(b, (ovs + 1) * dv, "R2");
            chk("R2", 32'(tx), 32'd1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule